// File: doc/BRIEF.md
# Fetch Run Boundary Selector

This unit sits at the front of an instruction fetch pipeline. Each cycle it looks at the aligned cache line that holds the current fetch address and decides which instruction slots of that line go forward as one fetch run. It also chooses the address to fetch from next. The line is made of fixed 4-byte slots, 16 slots to a 64-byte line. Two predecode flags come with each slot: one marks a branch and one marks a return-type branch. The start slot is taken from address bits [5:2].

Two direction predictions arrive each cycle. The first applies to the first branch at or after the start slot, and the second applies to the next branch after that one. A first branch that is predicted not taken does not end the run, so fetch can go on in a straight line until it reaches a second branch. A single target lookup port and the top entry of the return stack supply the redirect addresses. The target lookup is taken to describe the branch that ends the run. When the line is not present, the unit delivers nothing and keeps its fetch address.

Top module: `frb_fetch_run`

## Requirements
- R1: While reset is held and right after it is released, `fetch_pc` equals the parameter `RESET_VEC` (default 0x0000_1000).
- R2: `run_mask` has its set bits in one contiguous group that begins at slot `fetch_pc[5:2]`. The number of set bits equals `run_len`, and `run_len` never exceeds 8.
- R3: With no branch in range, the run ends at slot 15 if that comes before 8 slots are used. `next_pc` is then the base of the following line (line base + 64).
- R4: With no branch in range and at least 8 slots left in the line, the run is 8 slots long and `next_pc` = `fetch_pc` + 32.
- R5: A first branch predicted not taken (`pred_first`=0) is included in the run, and the run carries on past it.
- R6: A first branch predicted taken ends the run and is its last slot. When it is not a return and `btb_hit`=1, `next_pc` = `btb_target`.
- R7: A taken branch flagged as a return redirects to `ras_top`, even when `btb_hit`=1.
- R8: A first branch predicted taken that is not a return and has `btb_hit`=0 still ends the run, but `next_pc` is the sequential address just after it.
- R9: A second branch always ends the run and is included in it. If `pred_second`=0, or if it is not a return and `btb_hit`=0, `next_pc` is sequential past it. Otherwise `next_pc` follows R6 or R7.
- R10: When `line_hit`=0, `run_len`=0, `run_mask`=0, `next_pc`=`fetch_pc`, and `fetch_pc` does not change at the next clock edge.
- R11: When `line_hit`=1, `fetch_pc` takes the value of `next_pc` at the next rising clock edge.
- R12: A branch flag lying beyond the eight-slot limit has no effect: the run stays 8 slots long and `next_pc` stays sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_hit | input | 1 | The line for `fetch_pc` is present this cycle |
| brk_mask | input | 16 | Predecode branch flag for each slot |
| ret_mask | input | 16 | Predecode return-type flag for each slot |
| pred_first | input | 1 | Taken prediction for the first branch |
| pred_second | input | 1 | Taken prediction for the second branch |
| btb_hit | input | 1 | The target lookup hit for the run-ending branch |
| btb_target | input | 32 | Target from the lookup |
| ras_top | input | 32 | Top entry of the return stack |
| fetch_pc | output | 32 | Current fetch address |
| run_mask | output | 16 | Slots delivered this cycle |
| run_len | output | 4 | Number of slots delivered |
| next_pc | output | 32 | Address for the next fetch |

## Verification
Two boundary rules can hit the same slot: a branch can sit exactly on the last slot that the line end or the eight-slot cap allows. In that case the branch rule must pick the target, while the length still comes out the same. The bench sets this up by moving the start slot to 12 and placing a taken branch at slot 15. It also places a second branch at the eighth slot of a run that starts at slot 0. In both cases it checks that the length matches the cap and that `next_pc` is the redirect target and not the sequential address. A random sweep then compares every cycle against a slot-by-slot walk model written in the bench.

// File: rtl/frb_pkg.sv
package frb_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SEQ  = 2'd1,
    SRC_BTB  = 2'd2,
    SRC_RAS  = 2'd3
  } frb_src_e;
endpackage

// File: rtl/frb_scan.sv
module frb_scan #(
  parameter int SLOTS = 16,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] brk_mask,
  input  logic [SW-1:0]    start,
  output logic             b1_found,
  output logic [SW-1:0]    b1_pos,
  output logic             b2_found,
  output logic [SW-1:0]    b2_pos
);
  // lowest flagged slot at or after the start slot
  always_comb begin
    b1_found = 1'b0;
    b1_pos   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (brk_mask[i] && (i >= int'(start))) begin
        b1_found = 1'b1;
        b1_pos   = SW'(i);
      end
    end
  end

  // lowest flagged slot strictly after the first one
  always_comb begin
    b2_found = 1'b0;
    b2_pos   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (brk_mask[i] && b1_found && (i > int'(b1_pos))) begin
        b2_found = 1'b1;
        b2_pos   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/frb_steer.sv
module frb_steer
  import frb_pkg::*;
#(
  parameter int SLOTS   = 16,
  parameter int MAX_RUN = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             line_hit,
  input  logic [SW-1:0]    start,
  input  logic [SLOTS-1:0] ret_mask,
  input  logic             b1_found,
  input  logic [SW-1:0]    b1_pos,
  input  logic             b2_found,
  input  logic [SW-1:0]    b2_pos,
  input  logic             pred_first,
  input  logic             pred_second,
  input  logic             btb_hit,
  output logic [SW-1:0]    end_slot,
  output frb_src_e         src,
  output logic             brk_stop
);
  logic [SW:0]   lim_wide;
  logic [SW-1:0] lim;
  logic          b1_in, b2_in;

  // last slot allowed by both the run cap and the line end
  function automatic logic [SW:0] cap_slot(input logic [SW-1:0] s);
    return (SW+1)'(s) + (SW+1)'(MAX_RUN - 1);
  endfunction

  // where a taken branch redirects, or sequential when no target is known
  function automatic frb_src_e pick_src(input logic taken, input logic is_ret,
                                        input logic hit);
    if (taken && is_ret)   return SRC_RAS;
    else if (taken && hit) return SRC_BTB;
    else                   return SRC_SEQ;
  endfunction

  assign lim_wide = cap_slot(start);
  assign lim      = (lim_wide > (SW+1)'(SLOTS - 1)) ? SW'(SLOTS - 1) : lim_wide[SW-1:0];
  assign b1_in    = b1_found && (b1_pos <= lim);
  assign b2_in    = b2_found && (b2_pos <= lim);

  always_comb begin
    end_slot = lim;
    src      = SRC_SEQ;
    brk_stop = 1'b0;
    if (!line_hit) begin
      src = SRC_HOLD;
    end else if (b1_in && pred_first) begin
      end_slot = b1_pos;
      brk_stop = 1'b1;
      src      = pick_src(1'b1, ret_mask[b1_pos], btb_hit);
    end else if (b1_in && b2_in) begin
      end_slot = b2_pos;
      brk_stop = 1'b1;
      src      = pick_src(pred_second, ret_mask[b2_pos], btb_hit);
    end
  end
endmodule

// File: rtl/frb_pc_reg.sv
module frb_pc_reg #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= ADDR_W'(RESET_VEC);
    else if (load) q <= d;
  end
endmodule

// File: rtl/frb_fetch_run.sv
module frb_fetch_run
  import frb_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          SLOTS      = 16,
  parameter int          SLOT_BYTES = 4,
  parameter int          MAX_RUN    = 8,
  parameter logic [31:0] RESET_VEC  = 32'h0000_1000,
  localparam int SW    = $clog2(SLOTS),
  localparam int BW    = $clog2(SLOT_BYTES),
  localparam int LEN_W = $clog2(MAX_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_hit,
  input  logic [SLOTS-1:0]  brk_mask,
  input  logic [SLOTS-1:0]  ret_mask,
  input  logic              pred_first,
  input  logic              pred_second,
  input  logic              btb_hit,
  input  logic [ADDR_W-1:0] btb_target,
  input  logic [ADDR_W-1:0] ras_top,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [SLOTS-1:0]  run_mask,
  output logic [LEN_W-1:0]  run_len,
  output logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(SLOTS * SLOT_BYTES - 1);

  logic [SW-1:0] start;
  logic          b1_found, b2_found;
  logic [SW-1:0] b1_pos, b2_pos;
  logic [SW-1:0] end_slot;
  frb_src_e      src;
  // named events for the checker
  logic          brk_stop;
  logic          use_ras;
  logic          use_btb;

  // address of the slot following a given slot of the current line
  function automatic logic [ADDR_W-1:0] seq_after(input logic [ADDR_W-1:0] pc,
                                                  input logic [SW-1:0] e);
    return (pc & ~LINE_MASK) + ADDR_W'((int'(e) + 1) * SLOT_BYTES);
  endfunction

  function automatic logic [LEN_W-1:0] span(input logic [SW-1:0] s,
                                            input logic [SW-1:0] e);
    return LEN_W'(int'(e) - int'(s) + 1);
  endfunction

  assign start = fetch_pc[BW+SW-1:BW];

  frb_scan #(.SLOTS(SLOTS)) u_scan (
    .brk_mask (brk_mask),
    .start    (start),
    .b1_found (b1_found),
    .b1_pos   (b1_pos),
    .b2_found (b2_found),
    .b2_pos   (b2_pos)
  );

  frb_steer #(.SLOTS(SLOTS), .MAX_RUN(MAX_RUN)) u_steer (
    .line_hit    (line_hit),
    .start       (start),
    .ret_mask    (ret_mask),
    .b1_found    (b1_found),
    .b1_pos      (b1_pos),
    .b2_found    (b2_found),
    .b2_pos      (b2_pos),
    .pred_first  (pred_first),
    .pred_second (pred_second),
    .btb_hit     (btb_hit),
    .end_slot    (end_slot),
    .src         (src),
    .brk_stop    (brk_stop)
  );

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_mask
      assign run_mask[g] = line_hit && (SW'(g) >= start) && (SW'(g) <= end_slot);
    end
  endgenerate

  assign run_len = line_hit ? span(start, end_slot) : '0;
  assign use_ras = (src == SRC_RAS);
  assign use_btb = (src == SRC_BTB);

  always_comb begin
    unique case (src)
      SRC_HOLD: next_pc = fetch_pc;
      SRC_RAS:  next_pc = ras_top;
      SRC_BTB:  next_pc = btb_target;
      default:  next_pc = seq_after(fetch_pc, end_slot);
    endcase
  end

  frb_pc_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (line_hit),
    .d     (next_pc),
    .q     (fetch_pc)
  );
endmodule

// File: rtl/frb_fetch_run_chk.sv
module frb_fetch_run_chk #(
  parameter int          ADDR_W    = 32,
  parameter int          SLOTS     = 16,
  parameter int          MAX_RUN   = 8,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  localparam int LEN_W = $clog2(MAX_RUN + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_hit,
  input logic [ADDR_W-1:0] btb_target,
  input logic [ADDR_W-1:0] ras_top,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [SLOTS-1:0]  run_mask,
  input logic [LEN_W-1:0]  run_len,
  input logic [ADDR_W-1:0] next_pc,
  input logic              brk_stop,
  input logic              use_ras,
  input logic              use_btb
);
  // R1
  reset_vec_chk: assert property (@(posedge clk) !rst_n |=> fetch_pc == ADDR_W'(RESET_VEC));

  // R2
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_len) <= MAX_RUN);

  // R2
  mask_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(run_mask) == int'(run_len));

  // R3
  run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_hit && !brk_stop) |-> (int'(run_len) == MAX_RUN || run_mask[SLOTS-1]));

  // R6
  btb_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_btb |-> next_pc == btb_target);

  // R7
  ras_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    use_ras |-> next_pc == ras_top);

  // R10
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hit |-> (run_len == '0 && run_mask == '0));

  // R10
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hit |=> $stable(fetch_pc));

  // R11
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_hit |=> fetch_pc == $past(next_pc));
endmodule

bind frb_fetch_run frb_fetch_run_chk #(
  .ADDR_W(ADDR_W), .SLOTS(SLOTS), .MAX_RUN(MAX_RUN), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_hit   (line_hit),
  .btb_target (btb_target),
  .ras_top    (ras_top),
  .fetch_pc   (fetch_pc),
  .run_mask   (run_mask),
  .run_len    (run_len),
  .next_pc    (next_pc),
  .brk_stop   (brk_stop),
  .use_ras    (use_ras),
  .use_btb    (use_btb)
);

// File: tb/frb_fetch_run_tb.sv
module frb_fetch_run_tb;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RVEC       = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_hit = 1'b0;
  logic [15:0] brk_mask = '0;
  logic [15:0] ret_mask = '0;
  logic        pred_first = 1'b0;
  logic        pred_second = 1'b0;
  logic        btb_hit = 1'b0;
  logic [31:0] btb_target = '0;
  logic [31:0] ras_top = '0;
  logic [31:0] fetch_pc;
  logic [15:0] run_mask;
  logic [3:0]  run_len;
  logic [31:0] next_pc;

  int n_chk = 0;
  int n_bad = 0;

  frb_fetch_run u_dut (
    .clk(clk), .rst_n(rst_n), .line_hit(line_hit), .brk_mask(brk_mask),
    .ret_mask(ret_mask), .pred_first(pred_first), .pred_second(pred_second),
    .btb_hit(btb_hit), .btb_target(btb_target), .ras_top(ras_top),
    .fetch_pc(fetch_pc), .run_mask(run_mask), .run_len(run_len), .next_pc(next_pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    line_hit = 1'b1; brk_mask = '0; ret_mask = '0;
    pred_first = 1'b0; pred_second = 1'b0; btb_hit = 1'b0;
    btb_target = '0; ras_top = '0;
  endtask

  // move fetch_pc to addr with a taken branch at the current start slot
  task automatic steer_to(input logic [31:0] addr);
    @(negedge clk);
    idle_inputs();
    brk_mask[fetch_pc[5:2]] = 1'b1;
    pred_first = 1'b1; btb_hit = 1'b1; btb_target = addr;
    @(posedge clk); #1;
    chk(fetch_pc == addr, "R11 steer", fetch_pc, addr);
  endtask

  task automatic expect_run(input string req, input int len, input logic [31:0] nxt);
    #1;
    chk(int'(run_len) == len, req, 32'(run_len), 32'(len));
    chk(next_pc == nxt, req, next_pc, nxt);
  endtask

  task automatic t_reset();
    chk(fetch_pc == RVEC, "R1 reset", fetch_pc, RVEC);
  endtask

  task automatic t_plain();
    steer_to(32'h0000_2000);
    @(negedge clk); idle_inputs();
    expect_run("R4 full run", 8, 32'h0000_2020);
    chk(run_mask == 16'h00FF, "R2 mask", 32'(run_mask), 32'h00FF);
    @(posedge clk); #1;
    chk(fetch_pc == 32'h0000_2020, "R11 advance", fetch_pc, 32'h0000_2020);
  endtask

  task automatic t_line_end();
    steer_to(32'h0000_2030);
    @(negedge clk); idle_inputs();
    expect_run("R3 line end", 4, 32'h0000_2040);
    chk(run_mask == 16'hF000, "R2 mask start 12", 32'(run_mask), 32'hF000);
  endtask

  // taken branch on slot 15 when the run also meets the line end
  task automatic t_edge_both();
    steer_to(32'h0000_2030);
    @(negedge clk); idle_inputs();
    brk_mask[15] = 1'b1; pred_first = 1'b1; btb_hit = 1'b1; btb_target = 32'h0000_7000;
    expect_run("R6 taken at line end", 4, 32'h0000_7000);
  endtask

  task automatic t_first_nt();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[1] = 1'b1; brk_mask[3] = 1'b1; pred_second = 1'b1;
    btb_hit = 1'b1; btb_target = 32'h0000_2000;
    expect_run("R5 pass first", 4, 32'h0000_2000);
  endtask

  // second branch on the eighth slot: cap and branch coincide
  task automatic t_cap_branch();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[2] = 1'b1; brk_mask[7] = 1'b1; pred_second = 1'b1;
    ret_mask[7] = 1'b1; ras_top = 32'h0000_5500;
    expect_run("R9 second at cap", 8, 32'h0000_5500);
  endtask

  task automatic t_first_t();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[2] = 1'b1; brk_mask[5] = 1'b1; pred_first = 1'b1;
    btb_hit = 1'b1; btb_target = 32'h0000_3300;
    expect_run("R6 first taken", 3, 32'h0000_3300);
    chk(run_mask == 16'h0007, "R6 mask", 32'(run_mask), 32'h0007);
  endtask

  task automatic t_ret();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[0] = 1'b1; ret_mask[0] = 1'b1; pred_first = 1'b1;
    btb_hit = 1'b1; btb_target = 32'h0000_4000; ras_top = 32'h0000_5000;
    expect_run("R7 return", 1, 32'h0000_5000);
  endtask

  task automatic t_miss();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[4] = 1'b1; pred_first = 1'b1; btb_target = 32'h0000_4000;
    expect_run("R8 lookup miss", 5, 32'h0000_3014);
  endtask

  task automatic t_second_nt();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[1] = 1'b1; brk_mask[2] = 1'b1; brk_mask[4] = 1'b1;
    btb_hit = 1'b1; btb_target = 32'h0000_4000;
    expect_run("R9 second not taken", 3, 32'h0000_300C);
  endtask

  task automatic t_far_branch();
    steer_to(32'h0000_3000);
    @(negedge clk); idle_inputs();
    brk_mask[10] = 1'b1; pred_first = 1'b1; btb_hit = 1'b1; btb_target = 32'h0000_4000;
    expect_run("R12 far branch", 8, 32'h0000_3020);
  endtask

  task automatic t_hold();
    logic [31:0] was;
    steer_to(32'h0000_3010);
    was = fetch_pc;
    @(negedge clk); idle_inputs();
    line_hit = 1'b0; brk_mask = 16'hFFFF; pred_first = 1'b1; btb_hit = 1'b1;
    btb_target = 32'h0000_9000;
    expect_run("R10 no line", 0, was);
    chk(run_mask == 16'h0, "R10 mask", 32'(run_mask), 32'h0);
    @(posedge clk); #1;
    chk(fetch_pc == was, "R10 pc held", fetch_pc, was);
  endtask

  // slot-by-slot walk of the rules
  function automatic void model(input logic [31:0] pc, output int len,
                                output logic [15:0] msk, output logic [31:0] nxt);
    int s = int'(pc[5:2]);
    int seen = 0;
    bit stop = 0, tk = 0, rt = 0;
    len = 0; msk = '0;
    for (int i = 0; i < 16; i++) begin
      if (!stop && i >= s && len < 8) begin
        msk[i] = 1'b1; len++;
        if (brk_mask[i]) begin
          seen++;
          if (seen == 1 && pred_first) begin
            stop = 1; rt = ret_mask[i]; tk = ret_mask[i] || btb_hit;
          end else if (seen == 2) begin
            stop = 1; rt = ret_mask[i]; tk = pred_second && (ret_mask[i] || btb_hit);
          end
        end
      end
    end
    nxt = tk ? (rt ? ras_top : btb_target) : ((pc & ~32'h3F) + 32'(4 * (s + len)));
    if (!line_hit) begin len = 0; msk = '0; nxt = pc; end
  endfunction

  task automatic t_sweep();
    int el; logic [15:0] em; logic [31:0] en;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      line_hit = ($urandom % 8) != 0;
      brk_mask = 16'($urandom & $urandom & $urandom);
      ret_mask = 16'($urandom);
      pred_first = 1'($urandom); pred_second = 1'($urandom); btb_hit = 1'($urandom);
      btb_target = $urandom & 32'h0000_FFFC; ras_top = $urandom & 32'h0000_FFFC;
      #1;
      model(fetch_pc, el, em, en);
      chk(int'(run_len) == el, "R2 sweep len", 32'(run_len), 32'(el));
      chk(run_mask == em, "R2 sweep mask", 32'(run_mask), 32'(em));
      chk(next_pc == en, "R9 sweep next", next_pc, en);
      @(posedge clk); #1;
      chk(fetch_pc == en, "R11 sweep pc", fetch_pc, en);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_plain();
    t_line_end();
    t_edge_both();
    t_first_nt();
    t_cap_branch();
    t_first_t();
    t_ret();
    t_miss();
    t_second_nt();
    t_far_branch();
    t_hold();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule